// File: doc/BRIEF.md
# Analog Test Pulse Sequencer

This block produces a burst of test pulses for the analog test input of a pixel detector. An external analog switch chooses between two DAC output levels. The block drives that switch's select line. It holds the select on the baseline level at rest, and for each pulse it moves the select to the pulse level. It then returns the select to the baseline for an equal gap.

A single parameter word from the host sets the number of pulses and the width of each pulse. A second word holds the two DAC codes. The block captures these codes when a burst starts and passes them on to the DAC loading logic with a one-cycle load strobe.

The host starts a burst with a one-cycle strobe. The block raises a one-cycle completion flag after the final gap. An abort input ends a burst at any point.

Top module: `tps_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sw_pulse_o`, `busy_o`, `done_o` and `dac_load_o` are all low.
- R2: A start is accepted when the block is idle, `start_i` is high and `abort_i` is low. The field `prm_i[31:16]` gives the pulse count N and `prm_i[15:0]` gives the width W, in clock cycles. Count the cycle after the accepting edge as cycle 1. For each pulse, `sw_pulse_o` is high for W cycles and then low for W cycles, N times in a row. `busy_o` is high in cycles 1 to 2NW.
- R3: An accepted start with N = 0 gives `done_o` high in cycle 1. In that case `sw_pulse_o` stays low, `busy_o` stays low and `dac_load_o` stays low.
- R4: `done_o` is high for exactly one cycle, cycle 2NW+1, which directly follows the last low interval. In that cycle `busy_o` and `sw_pulse_o` are low.
- R5: A start strobe that arrives while `busy_o` is high is ignored. The length and shape of the running burst do not change, and the forwarded DAC codes stay as they were.
- R6: If `abort_i` is high at a clock edge, then in the next cycle `sw_pulse_o`, `busy_o` and `done_o` are low and the block is idle. No `done_o` pulse follows.
- R7: A width field of zero is treated as a width of one cycle.
- R8: When a start is accepted with N > 0, the baseline code `lvl_i[15:0]` and the pulse code `lvl_i[31:16]` are captured. In cycle 1 they appear on `dac_base_o` and `dac_pulse_o`, and `dac_load_o` is high for that one cycle only. The codes are held steady until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for a burst |
| abort_i | input | 1 | Ends any burst and returns to idle |
| prm_i | input | 32 | Pulse count in [31:16], pulse width in [15:0] |
| lvl_i | input | 32 | Pulse DAC code in [31:16], baseline DAC code in [15:0] |
| sw_pulse_o | output | 1 | Switch select: 1 selects the pulse DAC, 0 selects the baseline |
| busy_o | output | 1 | A burst is running |
| done_o | output | 1 | One-cycle completion flag |
| dac_base_o | output | 16 | Captured baseline DAC code |
| dac_pulse_o | output | 16 | Captured pulse DAC code |
| dac_load_o | output | 1 | One-cycle strobe asking the DAC logic to load the codes |

## Verification
A phase timer that is off by one shows up on `sw_pulse_o` at the first high-to-low edge, in cycle W+1. A pulse counter that is off by one moves `done_o` by 2W cycles. A state register that accepts a start while busy changes the burst length. It also changes the DAC codes, and that shows on `dac_base_o` and `dac_pulse_o` in the cycle after the stray strobe. Abort handling that is slow, or that leaves a stale phase behind, shows on `busy_o` or `sw_pulse_o` one cycle after `abort_i`.

// File: rtl/tps_pkg.sv
package tps_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HIGH = 2'd1,
    ST_LOW  = 2'd2,
    ST_DONE = 2'd3
  } tps_state_e;
endpackage

// File: rtl/tps_phase_timer.sv
module tps_phase_timer #(
  parameter int unsigned WID_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WID_W-1:0] width_i,
  input  logic             reload_i,
  input  logic             run_i,
  output logic             last_o
);
  logic [WID_W-1:0] wm1_q, cnt_q, wm1_d;

  // zero width behaves as one cycle
  assign wm1_d = (width_i == '0) ? '0 : width_i - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wm1_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      wm1_q <= wm1_d;
      cnt_q <= wm1_d;
    end else if (reload_i) begin
      cnt_q <= wm1_q;
    end else if (run_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last_o = (cnt_q == '0);

  p_timer_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= wm1_q);
endmodule

// File: rtl/tps_pulse_ctr.sv
module tps_pulse_ctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             dec_i,
  output logic             last_o
);
  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rem_q <= '0;
    else if (load_i)   rem_q <= cnt_i;
    else if (dec_i)    rem_q <= rem_q - 1'b1;
  end

  assign last_o = (rem_q == CNT_W'(1));

  p_no_underflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> rem_q > CNT_W'(1));
endmodule

// File: rtl/tps_dac_hold.sv
module tps_dac_hold #(
  parameter int unsigned DAC_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cap_i,
  input  logic [2*DAC_W-1:0] lvl_i,
  output logic [DAC_W-1:0]   base_o,
  output logic [DAC_W-1:0]   pulse_o,
  output logic               load_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o  <= '0;
      pulse_o <= '0;
      load_o  <= 1'b0;
    end else begin
      load_o <= cap_i;
      if (cap_i) begin
        base_o  <= lvl_i[DAC_W-1:0];
        pulse_o <= lvl_i[2*DAC_W-1:DAC_W];
      end
    end
  end

  p_codes_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(base_o) && $stable(pulse_o) && !load_o);
endmodule

// File: rtl/tps_top.sv
module tps_top
  import tps_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned WID_W = 16,
  parameter int unsigned DAC_W = 16,
  localparam int unsigned PRM_W = CNT_W + WID_W,
  localparam int unsigned LVL_W = 2 * DAC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [PRM_W-1:0] prm_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic             sw_pulse_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [DAC_W-1:0] dac_base_o,
  output logic [DAC_W-1:0] dac_pulse_o,
  output logic             dac_load_o
);
  tps_state_e state_q, state_d;
  logic [CNT_W-1:0] n_fld;
  logic [WID_W-1:0] w_fld;
  logic accept, go, t_last, p_last, t_reload, p_dec;

  assign n_fld    = prm_i[PRM_W-1:WID_W];
  assign w_fld    = prm_i[WID_W-1:0];
  assign accept   = (state_q == ST_IDLE) && start_i && !abort_i;
  assign go       = accept && (n_fld != '0);
  assign t_reload = !abort_i && t_last &&
                    ((state_q == ST_HIGH) || (state_q == ST_LOW && !p_last));
  assign p_dec    = !abort_i && t_last && state_q == ST_LOW && !p_last;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = go ? ST_HIGH : ST_DONE;
      ST_HIGH: if (t_last) state_d = ST_LOW;
      ST_LOW:  if (t_last) state_d = p_last ? ST_DONE : ST_HIGH;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (abort_i) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  tps_phase_timer #(.WID_W(WID_W)) u_timer (
    .clk_i, .rst_ni, .load_i(go), .width_i(w_fld), .reload_i(t_reload),
    .run_i(state_q == ST_HIGH || state_q == ST_LOW), .last_o(t_last)
  );

  tps_pulse_ctr #(.CNT_W(CNT_W)) u_pctr (
    .clk_i, .rst_ni, .load_i(go), .cnt_i(n_fld), .dec_i(p_dec), .last_o(p_last)
  );

  tps_dac_hold #(.DAC_W(DAC_W)) u_dac (
    .clk_i, .rst_ni, .cap_i(go), .lvl_i(lvl_i),
    .base_o(dac_base_o), .pulse_o(dac_pulse_o), .load_o(dac_load_o)
  );

  assign sw_pulse_o = (state_q == ST_HIGH);
  assign busy_o     = (state_q == ST_HIGH) || (state_q == ST_LOW);
  assign done_o     = (state_q == ST_DONE);

  p_abort_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !busy_o && !sw_pulse_o && !done_o);
  p_done_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_zero_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !done_o && start_i && !abort_i && n_fld == '0) |=> done_o && !sw_pulse_o);
  p_start_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> !dac_load_o);
  p_sel_only_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_pulse_o |-> busy_o);
endmodule

// File: tb/tps_top_tb_top.sv
module tps_top_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, abort = 1'b0;
  logic [31:0] prm = '0, lvl = '0;
  logic sw, busy, done, dload;
  logic [15:0] dbase, dpulse;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  tps_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .abort_i(abort),
    .prm_i(prm), .lvl_i(lvl), .sw_pulse_o(sw), .busy_o(busy), .done_o(done),
    .dac_base_o(dbase), .dac_pulse_o(dpulse), .dac_load_o(dload)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // launch a start with accept on the next posedge; returns at negedge of cycle 1
  task automatic launch(input int n, input int w, input logic [31:0] codes);
    prm = {n[15:0], w[15:0]};
    lvl = codes;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // R2 R4 R5 R7 R8: whole burst checked cycle by cycle
  task automatic t_train(input int n, input int w, input logic [31:0] codes, input bit intf);
    int we = (w == 0) ? 1 : w;
    int len = 2 * n * we;
    launch(n, w, codes);
    chk(dload === 1'b1, "R8 load strobe", dload, 1);
    chk(dbase === codes[15:0] && dpulse === codes[31:16], "R8 codes", {dpulse, dbase}, codes);
    for (int k = 1; k <= len + 2; k++) begin
      if (k <= len) begin
        bit e = (((k - 1) / we) % 2) == 0;
        chk(sw === e, "R2 switch shape", sw, e);
        chk(busy === 1'b1 && done === 1'b0, "R2 busy", {busy, done}, 2'b10);
        if (k > 1) chk(dload === 1'b0 && {dpulse, dbase} === codes, "R5 R8 held", {dpulse, dbase}, codes);
      end else if (k == len + 1) begin
        chk(done === 1'b1 && busy === 1'b0 && sw === 1'b0, "R4 done", {done, busy, sw}, 3'b100);
      end else begin
        chk(done === 1'b0, "R4 single done", done, 0);
      end
      if (intf && k == 2) begin
        prm = 32'h0000_0000;
        lvl = ~codes;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk(sw === 0 && busy === 0 && done === 0 && dload === 0, "R1 in reset", {sw, busy, done, dload}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(sw === 0 && busy === 0 && done === 0 && dload === 0, "R1 after reset", {sw, busy, done, dload}, 0);
  endtask

  task automatic t_zero;
    launch(0, 5, 32'h1111_2222);
    chk(done === 1 && sw === 0 && busy === 0 && dload === 0, "R3 zero count", {done, sw, busy, dload}, 4'b1000);
    @(negedge clk);
    chk(done === 0 && busy === 0, "R3 idle after", {done, busy}, 0);
  endtask

  task automatic t_abort;
    launch(3, 2, 32'h0A0A_0505);
    @(negedge clk);
    @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(sw === 0 && busy === 0 && done === 0, "R6 abort next cycle", {sw, busy, done}, 0);
    for (int i = 0; i < 15; i++) begin
      chk(done === 0 && busy === 0 && sw === 0, "R6 stays idle", {done, busy, sw}, 0);
      @(negedge clk);
    end
    // abort together with start: start not accepted
    prm = 32'h0002_0002; start = 1'b1; abort = 1'b1;
    @(negedge clk);
    start = 1'b0; abort = 1'b0;
    chk(busy === 0 && dload === 0 && done === 0, "R6 abort beats start", {busy, dload, done}, 0);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_train(3, 4, 32'hBEEF_0123, 1'b0);
    t_train(1, 1, 32'h7FFF_0001, 1'b0);
    t_zero();
    t_train(2, 0, 32'h00F0_000F, 1'b0);   // R7
    t_train(2, 3, 32'h4321_8765, 1'b1);   // R5
    t_abort();
    t_train(4, 2, 32'hCAFE_F00D, 1'b0);   // restart after abort
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule